// File: doc/BRIEF.md
# Two-Level Nested Interrupt Controller

This block sits between seven peripheral request lines and an 8-bit CPU core. Software programs an enable register and a level register over a small write port. On every clock the block masks the request levels with those registers. It ranks the survivors first by level and then by a fixed poll order. The winner is offered to the core as a request strobe together with a 16-bit service address.

Once the core acknowledges, the block marks the winning level as in service. Further requests are then gated by that state: a high-level request can interrupt a low-level routine, but nothing interrupts a high-level routine. A return pulse from the core retires the innermost active level. Clearing the request flags inside the peripherals is left to those peripherals.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, both registers read 00h, `cpu_irq` is 0, `cpu_vector` is 0000h and no level is in service.
- R2: A write with `reg_addr`=0 loads the enable register and `reg_addr`=1 loads the level register. `reg_rdata` returns the register that `reg_addr` selects. Bit 7 of the level register is reserved and always reads 0.
- R3: When enable bit 7 (global) is 0, no request is ever accepted.
- R4: Source i (request bit i) is accepted only if enable bit i is 1. The bit order is 0 ext0, 1 timer0, 2 ext1, 3 timer1, 4 serial, 5 timer2, 6 two-wire bus.
- R5: The vector is 0003h, 000Bh, 0013h, 001Bh, 0023h or 002Bh for sources 0 to 5 (8·i+3), and 0053h for source 6.
- R6: Within one level the winner is chosen in the order ext0, timer2, two-wire, timer0, ext1, timer1, serial.
- R7: A source whose level bit is 1 (high) wins over every low-level source, whatever the poll order.
- R8: Once raised, `cpu_irq` and `cpu_vector` hold unchanged until `cpu_ack` is sampled high; `cpu_irq` is low in the cycle after that.
- R9: While a low-level routine is in service, low-level requests are refused and high-level requests are accepted.
- R10: While a high-level routine is in service, no request is accepted.
- R11: A `cpu_reti` pulse clears the high in-service bit if it is set, otherwise the low one.
- R12: A qualifying request raises `cpu_irq` one clock edge after it is first sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 enable, 1 level |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| src_req | input | 7 | Synchronised request levels, bit order as in R4 |
| cpu_irq | output | 1 | Interrupt request strobe to the core |
| cpu_vector | output | 16 | Service address of the pending request |
| cpu_ack | input | 1 | Core accepts the pending request |
| cpu_reti | input | 1 | Core leaves the innermost service routine |

## Verification
The assertions assume that `cpu_ack` means something only while `cpu_irq` is high. They also assume that `cpu_reti` arrives only once per acknowledged request and that the request lines are already synchronous to `clk`. The bench drives every input on the falling edge. It acknowledges only a raised strobe, and it drops each request once that request has been acknowledged, standing in for a peripheral whose flag gets cleared. It issues exactly one return per acknowledge, so the in-service state never goes below empty.

// File: rtl/pic_pkg.sv
// Package: shared constants and helpers for the nested interrupt controller.
// Assumes a fixed set of seven sources; the poll order and the vector rule are fixed behaviour.
package pic_pkg;
    localparam int NSRC  = 7;
    localparam int IDX_W = $clog2(NSRC);
    localparam int DW    = 8;
    localparam int VEC_W = 16;

    typedef logic [NSRC-1:0]  src_vec_t;
    typedef logic [IDX_W-1:0] src_idx_t;

    // Source indices from first-polled to last-polled within one level.
    localparam int unsigned POLL [NSRC] = '{0, 5, 6, 1, 2, 3, 4};

    // Service address of a source: 8*i+3 for the first six, a separate slot for the last.
    function automatic logic [VEC_W-1:0] vec_of(input src_idx_t idx);
        logic [VEC_W-1:0] v;
        if (idx == src_idx_t'(NSRC-1))
            v = VEC_W'(16'h0053);
        else
            v = VEC_W'({idx, 3'b011});
        return v;
    endfunction
endpackage

// File: rtl/pic_regs.sv
// Module: enable and level registers with a one-bit-address write port.
// Assumes writes are single-cycle strobes; reads are combinational.
module pic_regs
    import pic_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_sel,
    output logic [DW-1:0] en_q,
    output logic [DW-1:0] lvl_q,
    output logic [DW-1:0] rd_data
);
    // Register update; the top bit of the level register is reserved and kept at 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            lvl_q <= '0;
        end else if (wr_en) begin
            if (wr_sel) lvl_q <= {1'b0, wr_data[DW-2:0]};
            else        en_q  <= wr_data;
        end
    end

    // Read-back multiplexer.
    always_comb rd_data = rd_sel ? lvl_q : en_q;

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_sel |=> lvl_q[DW-1] == 1'b0);
endmodule

// File: rtl/pic_arbiter.sv
// Module: combinational selection of the winning source.
// Masks requests, splits them by level, gates each level by the in-service state
// and picks the first source in the fixed poll order.
module pic_arbiter
    import pic_pkg::*;
(
    input  src_vec_t req,
    input  src_vec_t en,
    input  logic     gen_en,
    input  src_vec_t lvl,
    input  logic     ins_hi,
    input  logic     ins_lo,
    output logic     win_valid,
    output src_idx_t win_idx,
    output logic     win_hi
);
    src_vec_t cand, hi_set, lo_set;
    logic     hi_any, lo_any;
    src_idx_t hi_idx, lo_idx;

    // Walk the poll order backwards so the earliest polled source is kept.
    function automatic logic [IDX_W:0] first_polled(input src_vec_t s);
        logic [IDX_W:0] r;
        r = '0;
        for (int k = NSRC-1; k >= 0; k--) begin
            if (s[POLL[k]]) r = {1'b1, IDX_W'(POLL[k])};
        end
        return r;
    endfunction

    // Masking and level split.
    always_comb begin
        cand   = req & en & {NSRC{gen_en}};
        hi_set = cand & lvl;
        lo_set = cand & ~lvl;
        {hi_any, hi_idx} = first_polled(hi_set);
        {lo_any, lo_idx} = first_polled(lo_set);
    end

    // Level gating: high needs no high routine active, low needs no routine active.
    always_comb begin
        win_valid = 1'b0;
        win_hi    = 1'b0;
        win_idx   = '0;
        if (hi_any && !ins_hi) begin
            win_valid = 1'b1;
            win_hi    = 1'b1;
            win_idx   = hi_idx;
        end else if (lo_any && !ins_hi && !ins_lo) begin
            win_valid = 1'b1;
            win_idx   = lo_idx;
        end
    end
endmodule

// File: rtl/pic_tracker.sv
// Module: request strobe, vector hold and in-service level tracking.
// Assumes the core acknowledges only a raised strobe and returns once per acknowledge.
module pic_tracker
    import pic_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_valid,
    input  src_idx_t         win_idx,
    input  logic             win_hi,
    input  logic             cpu_ack,
    input  logic             cpu_reti,
    output logic             irq,
    output logic [VEC_W-1:0] vector,
    output logic             ins_hi,
    output logic             ins_lo
);
    logic pend_hi;
    logic take, clr_hi, clr_lo;

    // Strobe and vector: latch a winner when idle, hold until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq     <= 1'b0;
            vector  <= '0;
            pend_hi <= 1'b0;
        end else if (irq) begin
            if (cpu_ack) irq <= 1'b0;
        end else if (win_valid) begin
            irq     <= 1'b1;
            vector  <= vec_of(win_idx);
            pend_hi <= win_hi;
        end
    end

    // Return retires the innermost level; acknowledge enters the pending one.
    always_comb begin
        take   = irq && cpu_ack;
        clr_hi = cpu_reti && ins_hi;
        clr_lo = cpu_reti && !ins_hi && ins_lo;
    end

    // In-service bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ins_hi <= 1'b0;
            ins_lo <= 1'b0;
        end else begin
            ins_hi <= (ins_hi && !clr_hi) || (take && pend_hi);
            ins_lo <= (ins_lo && !clr_lo) || (take && !pend_hi);
        end
    end

    a_r8_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !cpu_ack |=> irq && $stable(vector));
    a_r8_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        irq && cpu_ack |=> !irq);
    a_r10_high_blocks_all: assert property (@(posedge clk) disable iff (!rst_n)
        ins_hi |-> !win_valid);
    a_r9_low_blocks_low: assert property (@(posedge clk) disable iff (!rst_n)
        ins_lo && win_valid |-> win_hi);
    a_r11_reti_high_first: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_reti && ins_hi && !irq |=> !ins_hi && (ins_lo == $past(ins_lo)));
endmodule

// File: rtl/nest_irq_ctrl.sv
// Module: top of the two-level nested interrupt controller.
// Assumes src_req is already synchronous to clk and that peripheral flags are cleared elsewhere.
module nest_irq_ctrl
    import pic_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    input  logic [NSRC-1:0]  src_req,
    output logic             cpu_irq,
    output logic [VEC_W-1:0] cpu_vector,
    input  logic             cpu_ack,
    input  logic             cpu_reti
);
    logic [DW-1:0] en_q, lvl_q;
    logic          win_valid, win_hi, ins_hi, ins_lo;
    src_idx_t      win_idx;

    pic_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wr_sel  (reg_addr),
        .wr_data (reg_wdata),
        .rd_sel  (reg_addr),
        .en_q    (en_q),
        .lvl_q   (lvl_q),
        .rd_data (reg_rdata)
    );

    pic_arbiter u_arb (
        .req       (src_req),
        .en        (en_q[NSRC-1:0]),
        .gen_en    (en_q[DW-1]),
        .lvl       (lvl_q[NSRC-1:0]),
        .ins_hi    (ins_hi),
        .ins_lo    (ins_lo),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_hi    (win_hi)
    );

    pic_tracker u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_hi    (win_hi),
        .cpu_ack   (cpu_ack),
        .cpu_reti  (cpu_reti),
        .irq       (cpu_irq),
        .vector    (cpu_vector),
        .ins_hi    (ins_hi),
        .ins_lo    (ins_lo)
    );

    a_r3_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_irq) |-> $past(en_q[DW-1]));
    a_r4_source_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> en_q[win_idx] && src_req[win_idx]);
endmodule

// File: tb/sim_nest_irq_ctrl.sv
`timescale 1ns/100ps
module sim_nest_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [6:0]  src_req = '0;
    logic        cpu_irq;
    logic [15:0] cpu_vector;
    logic        cpu_ack = 1'b0;
    logic        cpu_reti = 1'b0;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    nest_irq_ctrl u0 (.*);

    // {enable, level, request, expected strobe, expected vector}
    localparam int NV = 20;
    localparam logic [40:0] TBL [NV] = '{
        {8'h00, 8'h00, 8'h7F, 1'b0, 16'h0000},  // R3
        {8'h7F, 8'h00, 8'h7F, 1'b0, 16'h0000},  // R3
        {8'h81, 8'h00, 8'h01, 1'b1, 16'h0003},  // R5
        {8'hFF, 8'h00, 8'h02, 1'b1, 16'h000B},
        {8'hFF, 8'h00, 8'h04, 1'b1, 16'h0013},
        {8'hFF, 8'h00, 8'h08, 1'b1, 16'h001B},
        {8'hFF, 8'h00, 8'h10, 1'b1, 16'h0023},
        {8'hFF, 8'h00, 8'h20, 1'b1, 16'h002B},
        {8'hFF, 8'h00, 8'h40, 1'b1, 16'h0053},
        {8'hFF, 8'h00, 8'h7F, 1'b1, 16'h0003},  // R6
        {8'hFF, 8'h00, 8'h7E, 1'b1, 16'h002B},
        {8'hFF, 8'h00, 8'h5E, 1'b1, 16'h0053},
        {8'hFF, 8'h00, 8'h1E, 1'b1, 16'h000B},
        {8'hFF, 8'h00, 8'h1C, 1'b1, 16'h0013},
        {8'hFF, 8'h00, 8'h18, 1'b1, 16'h001B},
        {8'hFF, 8'h10, 8'h11, 1'b1, 16'h0023},  // R7
        {8'hFF, 8'h08, 8'h29, 1'b1, 16'h001B},  // R7
        {8'hC0, 8'h00, 8'h3F, 1'b0, 16'h0000},  // R4
        {8'hC2, 8'h00, 8'h41, 1'b1, 16'h0053},  // R4
        {8'h84, 8'h00, 8'h7B, 1'b0, 16'h0000}   // R4
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // Acknowledge a raised strobe, drop the requests, then return.
    task automatic serve_and_return();
        if (cpu_irq) begin
            cpu_ack = 1'b1; src_req = '0;
            @(negedge clk);
            cpu_ack = 1'b0; cpu_reti = 1'b1;
            @(negedge clk);
            cpu_reti = 1'b0;
        end
        src_req = '0;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", cpu_irq, 0);
        chk("R1 vector", cpu_vector, 0);
        reg_addr = 1'b0; #0.1;
        chk("R1 enable reg", reg_rdata, 8'h00);
        reg_addr = 1'b1; #0.1;
        chk("R1 level reg", reg_rdata, 8'h00);

        // R2 write and read back, reserved bit
        wr(1'b0, 8'hA5);
        wr(1'b1, 8'hFF);
        reg_addr = 1'b0; #0.1;
        chk("R2 enable readback", reg_rdata, 8'hA5);
        reg_addr = 1'b1; #0.1;
        chk("R2 level reserved bit", reg_rdata, 8'h7F);

        // Table walk: R3 R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            wr(1'b0, TBL[i][40:33]);
            wr(1'b1, TBL[i][32:25]);
            src_req = TBL[i][23:17];
            @(negedge clk);
            chk($sformatf("R3/R4/R6/R7 row %0d irq", i), cpu_irq, TBL[i][16]);
            if (TBL[i][16]) chk($sformatf("R5/R6/R7 row %0d vector", i), cpu_vector, TBL[i][15:0]);
            serve_and_return();
        end

        // R12 one edge of latency
        wr(1'b0, 8'hFF); wr(1'b1, 8'h00);
        src_req = 7'h08; #0.5;
        chk("R12 not before edge", cpu_irq, 0);
        @(negedge clk);
        chk("R12 raised after edge", cpu_irq, 1);

        // R8 hold while unacknowledged, even if requests change
        src_req = 7'h01;
        repeat (3) @(negedge clk);
        chk("R8 irq held", cpu_irq, 1);
        chk("R8 vector held", cpu_vector, 16'h001B);
        cpu_ack = 1'b1; src_req = '0;
        @(negedge clk);
        cpu_ack = 1'b0;
        chk("R8 irq drops after ack", cpu_irq, 0);
        // low level now in service
        cpu_reti = 1'b1; @(negedge clk); cpu_reti = 1'b0;

        // R9 nesting: low routine active
        wr(1'b1, 8'h01);
        src_req = 7'h08;
        @(negedge clk);
        chk("R9 low accepted when idle", cpu_vector, 16'h001B);
        cpu_ack = 1'b1; src_req = '0;
        @(negedge clk);
        cpu_ack = 1'b0;
        src_req = 7'h02;
        repeat (2) @(negedge clk);
        chk("R9 low blocked by low", cpu_irq, 0);
        src_req = 7'h03;
        @(negedge clk);
        chk("R9 high preempts irq", cpu_irq, 1);
        chk("R9 high preempts vector", cpu_vector, 16'h0003);
        cpu_ack = 1'b1; src_req = '0;
        @(negedge clk);
        cpu_ack = 1'b0;

        // R10 high routine active blocks everything
        src_req = 7'h03;
        repeat (2) @(negedge clk);
        chk("R10 all blocked under high", cpu_irq, 0);
        src_req = 7'h02;

        // R11 first return clears high only
        cpu_reti = 1'b1; @(negedge clk); cpu_reti = 1'b0;
        repeat (2) @(negedge clk);
        chk("R11 low still in service", cpu_irq, 0);
        cpu_reti = 1'b1; @(negedge clk); cpu_reti = 1'b0;
        @(negedge clk);
        chk("R11 second return frees low", cpu_irq, 1);
        chk("R11 vector after return", cpu_vector, 16'h000B);
        serve_and_return();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule